// File: doc/BRIEF.md
# Serial Receiver with Flagged Character Buffer

This block turns an asynchronous serial input line into characters. It oversamples the line with a 16x baud enable, checks each start bit at its midpoint and assembles 5 to 8 data bits, LSB first. Parity is optional and can be even, odd or fixed. It then samples the first stop bit. Each finished character goes into a receive buffer together with four error flags. The buffer is a FIFO of `DEPTH` entries when buffering is on, and a single holding slot when it is off.

Software-side logic takes entries from the buffer through a valid/ready read stream. `rd_valid` is high whenever the buffer holds an entry, and `rd_data` shows the oldest entry. One entry is popped on each clock edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, the head entry is held unchanged. The receiver itself cannot be stalled: a character that completes while the buffer is full is lost and recorded as an overrun. A separate four-bit status register repeats the error flags of the entry most recently popped. It latches an overrun as soon as one happens. A one-cycle `sts_clr` pulse, which stands for a write of any value, clears it.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_empty`=1, `rx_full`=0, `rd_valid`=0 and `sts_flags`=0.
- R2: A character is framed by one low start bit, 5+`word_len` data bits sent LSB first, an optional parity bit and a stop bit. Its data bits appear in `rd_data[7:0]`, and the bits above the word length read 0. The `word_len` encoding is 0=5, 1=6, 2=7 and 3=8 bits.
- R3: With `par_en`=1, `rd_data[9]` (parity error) is set when the received parity bit differs from the expected one. For `par_stick`=0 the expected bit gives an even (`par_even`=1) or odd (`par_even`=0) count of ones over data plus parity. For `par_stick`=1 the expected bit is the inverse of `par_even`.
- R4: `rd_data[8]` (framing error) is set when the first stop bit is sampled low. A second stop bit is never checked, even with `two_stop`=1.
- R5: A line held low through the whole frame, stop bit included, yields one entry of 0x500: break `rd_data[10]` and framing set, parity clear, character 0. No further character starts until the line has returned high.
- R6: Read stream: `rd_valid` = buffer not empty. Entries leave in arrival order. While `rd_valid`=1 and `rd_ready`=0, `rd_data` holds steady.
- R7: With `fifo_en`=1 the buffer holds `DEPTH` entries and `rx_full` rises at `DEPTH`. With `fifo_en`=0 it holds one entry and `rx_full` rises at one. `rx_empty` reports an empty buffer.
- R8: A character that completes while `rx_full`=1 is discarded. The overrun status `sts_flags[3]` sets on the next cycle, before any read. The next stored character carries overrun in `rd_data[11]`.
- R9: On each pop, `sts_flags[2:0]` (break, parity, framing) take bits 10..8 of the popped entry. Newly received characters do not change them.
- R10: A cycle with `sts_clr`=1 clears all four `sts_flags` bits.
- R11: A new start bit is accepted only while `uart_en` and `rx_en` are both 1. Dropping either in mid-character still completes and stores that character.
- R12: A low pulse shorter than half a bit period is rejected at the start-bit check and stores nothing.
- R13: All bit timing counts `tick16` enables only. A bit lasts 16 enables, whatever the clock-to-enable ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line, idle high |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Fixed parity select |
| two_stop | input | 1 | Two stop bits selected (only the first is checked) |
| fifo_en | input | 1 | Buffer depth `DEPTH` when 1, one entry when 0 |
| uart_en | input | 1 | Block enable |
| rx_en | input | 1 | Receive enable |
| rd_valid | output | 1 | Head entry available |
| rd_ready | input | 1 | Consumer takes head entry |
| rd_data | output | 12 | {overrun, break, parity, framing, character[7:0]} |
| sts_flags | output | 4 | {overrun, break, parity, framing} status |
| sts_clr | input | 1 | Clear pulse for status |
| rx_empty | output | 1 | Buffer empty |
| rx_full | output | 1 | Buffer full at current depth |

## Verification
The bench works the overrun path in both depth modes. A design that set the overrun status only on a read would show 0 right after the lost character. One that stored the lost character, or left out bit 11 on the next entry, would give the wrong read sequence. The status register is checked after a receive that is not yet popped, to catch a design that copies flags on arrival rather than on pop. Break, a framing error with the second stop bit absent, short glitches, a halved enable rate and an enable drop in mid-character each target a separate timing mistake. These would show up as spurious entries, a missing entry, or a wrongly reported error.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int CHAR_W  = 8;
  localparam int ENTRY_W = 12;
  localparam int F_FRM = 8;
  localparam int F_PAR = 9;
  localparam int F_BRK = 10;
  localparam int F_OVR = 11;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAIT_HI
  } rx_state_e;

  typedef struct packed {
    logic brk;
    logic par;
    logic frm;
  } rx_err_t;
endpackage

// File: rtl/rx_deframer.sv
module rx_deframer
  import rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              tick16,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              go,
  output logic              done,
  output logic [CHAR_W-1:0] chr,
  output rx_err_t           err
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] sync_q;
  logic              rx_s;
  rx_state_e         state;
  logic [3:0]        cnt;
  logic [2:0]        bitn;
  logic [CHAR_W-1:0] shreg;
  logic              par_bit;
  logic              par_exp;
  logic [2:0]        last_bit;

  assign rx_s     = sync_q[SYNC_N-1];
  assign last_bit = 3'(word_len) + 3'd4;
  assign par_exp  = par_stick ? ~par_even : (par_even ? ^shreg : ~^shreg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_N-2:0], rx_line};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; bitn <= '0; shreg <= '0;
      par_bit <= 1'b0; done <= 1'b0; chr <= '0; err <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (go && !rx_s) begin
          state <= S_START; cnt <= '0;
        end
        S_START: if (tick16) begin
          if (cnt == 4'd7) begin
            cnt <= '0; bitn <= '0; shreg <= '0;
            state <= rx_s ? S_IDLE : S_DATA;
          end else cnt <= cnt + 4'd1;
        end
        S_DATA: if (tick16) begin
          if (cnt == 4'd15) begin
            cnt <= '0;
            shreg[bitn] <= rx_s;
            if (bitn == last_bit) state <= par_en ? S_PAR : S_STOP;
            else bitn <= bitn + 3'd1;
          end else cnt <= cnt + 4'd1;
        end
        S_PAR: if (tick16) begin
          if (cnt == 4'd15) begin
            cnt <= '0; par_bit <= rx_s; state <= S_STOP;
          end else cnt <= cnt + 4'd1;
        end
        S_STOP: if (tick16) begin
          if (cnt == 4'd15) begin
            cnt  <= '0;
            done <= 1'b1;
            if (!rx_s && shreg == '0 && (!par_en || !par_bit)) begin
              chr <= '0;
              err <= '{brk: 1'b1, par: 1'b0, frm: 1'b1};
            end else begin
              chr <= shreg;
              err <= '{brk: 1'b0, par: par_en && (par_bit != par_exp), frm: !rx_s};
            end
            state <= rx_s ? S_IDLE : S_WAIT_HI;
          end else cnt <= cnt + 4'd1;
        end
        S_WAIT_HI: if (rx_s) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !go) |=> state == S_IDLE);
  a_r5_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT_HI && !rx_s) |=> state == S_WAIT_HI);
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer
  import rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en,
  input  logic               push,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head,
  output logic               empty,
  output logic               full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wptr, rptr;
  logic [CW-1:0]      count;
  logic [CW-1:0]      cap;

  assign cap   = fifo_en ? CW'(DEPTH) : CW'(1);
  assign empty = (count == '0);
  assign full  = (count >= cap);
  assign head  = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (push && !full) wptr <= nxt(wptr);
      if (pop && !empty) rptr <= nxt(rptr);
      count <= count + CW'(push && !full) - CW'(pop && !empty);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) a_r7_no_overflow: assert (count <= CW'(DEPTH));
  end
  a_r7_last_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(1) && pop && !push) |=> empty);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_line,
  input  logic        tick16,
  input  logic [1:0]  word_len,
  input  logic        par_en,
  input  logic        par_even,
  input  logic        par_stick,
  input  logic        two_stop,
  input  logic        fifo_en,
  input  logic        uart_en,
  input  logic        rx_en,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [11:0] rd_data,
  output logic [3:0]  sts_flags,
  input  logic        sts_clr,
  output logic        rx_empty,
  output logic        rx_full
);
  logic              done;
  logic [CHAR_W-1:0] chr;
  rx_err_t           err;
  logic              ovr_evt, push, pop, pend_ovr;
  logic              unused_cfg;

  assign unused_cfg = two_stop;

  rx_deframer u_deframer (
    .clk, .rst_n, .rx_line, .tick16, .word_len, .par_en, .par_even,
    .par_stick, .go(uart_en && rx_en), .done, .chr, .err
  );

  assign ovr_evt  = done && rx_full;
  assign push     = done && !rx_full;
  assign pop      = rd_valid && rd_ready;
  assign rd_valid = !rx_empty;

  rx_buffer #(.DEPTH(DEPTH)) u_buffer (
    .clk, .rst_n, .fifo_en, .push,
    .wdata({pend_ovr, err.brk, err.par, err.frm, chr}),
    .pop, .head(rd_data), .empty(rx_empty), .full(rx_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_ovr <= 1'b0;
    else if (ovr_evt) pend_ovr <= 1'b1;
    else if (push) pend_ovr <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_flags <= '0;
    else if (sts_clr) sts_flags <= '0;
    else begin
      if (pop) sts_flags[2:0] <= rd_data[F_BRK:F_FRM];
      if (ovr_evt) sts_flags[3] <= 1'b1;
    end
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  a_r8_ovr_now: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !sts_clr) |=> sts_flags[3]);
  a_r9_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !sts_clr) |=> sts_flags[2:0] == $past(rd_data[10:8]));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clr |=> sts_flags == 4'd0);
endmodule

// File: tb/test_serial_rx_core.sv
module test_serial_rx_core;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0, rx_line = 1, tick16 = 1;
  logic [1:0] word_len = 2'd3;
  logic par_en = 0, par_even = 0, par_stick = 0, two_stop = 0;
  logic fifo_en = 1, uart_en = 1, rx_en = 1, rd_ready = 0, sts_clr = 0;
  logic rd_valid, rx_empty, rx_full;
  logic [11:0] rd_data;
  logic [3:0] sts_flags;
  logic slow = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tick16 <= slow ? ~tick16 : 1'b1;

  serial_rx_core #(.DEPTH(DEPTH)) i_serial_rx_core (
    .clk, .rst_n, .rx_line, .tick16, .word_len, .par_en, .par_even,
    .par_stick, .two_stop, .fifo_en, .uart_en, .rx_en, .rd_valid,
    .rd_ready, .rd_data, .sts_flags, .sts_clr, .rx_empty, .rx_full
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int bits);
    rx_line = v;
    repeat (bits * (slow ? 32 : 16)) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input bit bad_par, input logic stop1, input int gap);
    int nb = 5 + int'(word_len);
    logic [7:0] m = d & 8'((1 << nb) - 1);
    logic pb = par_stick ? ~par_even : (par_even ? ^m : ~^m);
    hold(1'b0, 1);
    for (int i = 0; i < nb; i++) hold(m[i], 1);
    if (par_en) hold(pb ^ bad_par, 1);
    hold(stop1, 1);
    rx_line = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pop_chk(input string req, input logic [11:0] exp);
    chk({req, " valid"}, rd_valid, 1'b1);
    chk({req, " data"}, rd_data, exp);
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
  endtask

  task automatic clr_sts;
    sts_clr = 1; @(negedge clk); sts_clr = 0;
  endtask

  task automatic t_reset;
    chk("R1 empty", rx_empty, 1); chk("R1 full", rx_full, 0);
    chk("R1 valid", rd_valid, 0); chk("R1 sts", sts_flags, 0);
  endtask

  task automatic t_lengths;
    send_char(8'hA5, 0, 1, 8); pop_chk("R2 8bit", 12'h0A5);
    word_len = 2'd0; send_char(8'hF5, 0, 1, 8); pop_chk("R2 5bit", 12'h015);
    word_len = 2'd2; send_char(8'hDA, 0, 1, 8); pop_chk("R2 7bit", 12'h05A);
    word_len = 2'd3;
  endtask

  task automatic t_parity;
    par_en = 1; par_even = 1;
    send_char(8'h41, 0, 1, 8); pop_chk("R3 even ok", 12'h041);
    send_char(8'h41, 1, 1, 8); pop_chk("R3 even bad", 12'h241);
    chk("R9 sts after pop", sts_flags, 4'b0010);
    send_char(8'h13, 0, 1, 8);
    chk("R9 no update on rx", sts_flags, 4'b0010);
    par_even = 0; pop_chk("R3 odd/prev", 12'h013);
    chk("R9 sts cleared by pop", sts_flags, 4'b0000);
    send_char(8'h13, 0, 1, 8); pop_chk("R3 odd ok", 12'h013);
    par_stick = 1; send_char(8'h00, 1, 1, 8); pop_chk("R3 stick bad", 12'h200);
    send_char(8'h07, 0, 1, 8); pop_chk("R3 stick ok", 12'h007);
    par_en = 0; par_stick = 0;
    clr_sts; chk("R10 clear", sts_flags, 0);
  endtask

  task automatic t_stop;
    two_stop = 1;
    send_char(8'h3C, 0, 0, 20); pop_chk("R4 framing", 12'h13C);
    send_char(8'h11, 0, 1, 0); send_char(8'h22, 0, 1, 8);
    pop_chk("R4 first", 12'h011); pop_chk("R4 second unchecked", 12'h022);
    two_stop = 0;
    hold(1'b0, 14); rx_line = 1; repeat (20) @(negedge clk);
    pop_chk("R5 break", 12'h500);
    chk("R5 single entry", rx_empty, 1);
    chk("R9 break sts", sts_flags, 4'b0101);
    clr_sts;
  endtask

  task automatic t_glitch;
    rx_line = 0; repeat (5) @(negedge clk); rx_line = 1;
    repeat (200) @(negedge clk);
    chk("R12 glitch ignored", rx_empty, 1);
  endtask

  task automatic t_enable;
    fork
      send_char(8'h6E, 0, 1, 8);
      begin repeat (40) @(negedge clk); rx_en = 0; end
    join
    pop_chk("R11 finish char", 12'h06E);
    send_char(8'h55, 0, 1, 8);
    chk("R11 disabled", rx_empty, 1);
    rx_en = 1; uart_en = 0;
    send_char(8'h55, 0, 1, 8);
    chk("R11 uart off", rx_empty, 1);
    uart_en = 1;
  endtask

  task automatic t_stream;
    send_char(8'h01, 0, 1, 4); send_char(8'h02, 0, 1, 4);
    repeat (5) @(negedge clk);
    chk("R6 hold head", rd_data, 12'h001);
    pop_chk("R6 order a", 12'h001); pop_chk("R6 order b", 12'h002);
    chk("R7 empty", rx_empty, 1);
  endtask

  task automatic t_single_ovr;
    fifo_en = 0;
    send_char(8'hAA, 0, 1, 4);
    chk("R7 one-deep full", rx_full, 1);
    send_char(8'hBB, 0, 1, 4);
    chk("R8 sts immediate", sts_flags[3], 1);
    pop_chk("R8 kept first", 12'h0AA);
    chk("R8 sts kept", sts_flags[3], 1);
    send_char(8'hCC, 0, 1, 4);
    pop_chk("R8 flag on next", 12'h8CC);
    chk("R9 ovr popped sts", sts_flags, 4'b1000);
    clr_sts; chk("R10 clear ovr", sts_flags, 0);
    fifo_en = 1;
  endtask

  task automatic t_fifo_full;
    for (int i = 0; i < DEPTH; i++) send_char(8'(8'h30 + i), 0, 1, 0);
    repeat (4) @(negedge clk);
    chk("R7 full at depth", rx_full, 1);
    send_char(8'hEE, 0, 1, 4);
    chk("R8 fifo ovr", sts_flags[3], 1);
    for (int i = 0; i < DEPTH; i++) pop_chk("R7 drain", 12'(8'h30 + i));
    chk("R7 drained", rx_empty, 1);
    clr_sts;
    send_char(8'h44, 0, 1, 4); pop_chk("R8 next flagged", 12'h844);
    clr_sts;
  endtask

  task automatic t_slow;
    slow = 1;
    send_char(8'h9C, 0, 1, 8); pop_chk("R13 half rate", 12'h09C);
    slow = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_lengths; t_parity; t_stop; t_glitch;
    t_enable; t_stream; t_single_ovr; t_fifo_full; t_slow;
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(negedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule